// File: doc/BRIEF.md
# IR-Modulating Timer Pair

This block pairs a 16-bit general-purpose timer with a small 8-bit carrier timer. The main timer has a programmable clock divider, a programmable wrap value and five channels. Each channel either drives a PWM output or captures the counter value on chosen edges of an input pin. The carrier timer has its own divider, wrap value and one PWM compare.

In infrared mode, the main timer no longer counts divided clocks. It counts completed carrier periods instead. Channel 0 of the main timer gates the carrier PWM through an AND gate, which produces bursts of carrier on a dedicated output. All configuration is written through a simple address/data write port. Events are reported on sticky flags that software clears by writing ones.

Top module: `ir_timer_pair`

## Requirements
- R1: While running, the main counter advances once every (div+1) clocks, where div is written at address 1 (bits 7:0). A tick taken while the count is equal to or above the active wrap value returns the count to 0. When stopped, the counter holds its value.
- R2: The overflow flag, bit 5 of the flag set, goes high on the clock on which the main counter returns to 0 because of a wrap.
- R3: Wrap values (address 2 for the main timer, address 4 for the carrier) and compare values (address 5 for the carrier, addresses 8+i for channel i) go to shadow registers. While running, each timer copies its shadows into its active values only on its own wrap. While stopped, the copy happens on every clock.
- R4: A channel in PWM mode (mode bit 0 = 0) drives its output high while the main count is below its active compare value. A channel in capture mode drives its output low.
- R5: The carrier counter uses its own divider (address 3, bits 7:0). It wraps after reaching its wrap value (address 4). The carrier output is high while the carrier count is below the active carrier compare value.
- R6: In infrared mode (control bit 1), the main counter takes exactly one tick per carrier wrap. The infrared output equals channel 0's output ANDed with the carrier output. Outside infrared mode, the infrared output is 0.
- R7: A channel in capture mode (mode at address 16+i: bit 0 = capture, bit 1 = rising, bit 2 = falling) sees its pin through a two-flop synchronizer and an edge detector. When the pin changes before clock edge k, the main count present at edge k+2 is stored as that channel's capture value.
- R8: A pin pulse that spans at least one sampling clock edge, even a pulse one clock long, is recognized as both a rising and a falling edge.
- R9: A channel flag goes high on a capture event, or on a counter tick while in PWM mode with the count equal to the active compare value. Writing a 1 at address 6 clears a flag (bits 4:0 for the channels, bit 5 for overflow). When a set and a clear fall in the same clock, the set wins.
- R10: Control at address 0: bit 0 runs both timers and bit 1 selects infrared mode. Both dividers restart from 0 while stopped. After reset all counts, flags, outputs and capture values are 0, and both wrap values are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Register write address |
| wrData | input | 16 | Register write data |
| capIn | input | 5 | Capture pins, one per channel |
| chanOut | output | 5 | Channel PWM outputs |
| carOut | output | 1 | Carrier PWM output |
| irOut | output | 1 | Gated infrared output |
| cnt | output | 16 | Main counter value |
| capVal | output | 80 | Capture values, channel i at bits 16i+15:16i |
| chanFlag | output | 5 | Channel event flags |
| ovfFlag | output | 1 | Main counter overflow flag |

## Verification
Two pairs of events can land in the same clock. The first pair is a flag being set by a compare match, capture or wrap, and a write that clears that flag. The second pair is a shadow write to a wrap or compare value, and the wrap that would load it. Clear writes are issued back-to-back over many clocks while matches and captures are pending, and a wrap value is rewritten in the middle of a period. A behavioural reference model follows every register, wrap and synchronizer delay. It is compared on every clock, so set-over-clear priority and the old-period-then-new-period sequence are judged on the exact cycle.

// File: rtl/irtp_pkg.sv
package irtp_pkg;
  typedef struct packed {
    logic runEn;
    logic irSel;
    logic mainPreTick;
    logic carTick;
  } strobe_t;
endpackage

// File: rtl/irtp_sync.sv
module irtp_sync (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic sNow,
  output logic sPrev
);
  logic stage1;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1 <= 1'b0;
      sNow   <= 1'b0;
      sPrev  <= 1'b0;
    end else begin
      stage1 <= pinIn;
      sNow   <= stage1;
      sPrev  <= sNow;
    end
  end
endmodule

// File: rtl/irtp_ctrl.sv
module irtp_ctrl import irtp_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int CAR_W = 8,
  parameter int PRE_W = 8,
  parameter int NCH   = 5,
  parameter int AW    = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [AW-1:0]          wrAddr,
  input  logic [CNT_W-1:0]       wrData,
  output strobe_t                strb,
  output logic [CNT_W-1:0]       perSh,
  output logic [CAR_W-1:0]       carPerSh,
  output logic [CAR_W-1:0]       carCmpSh,
  output logic [NCH*CNT_W-1:0]   cmpSh,
  output logic [NCH*3-1:0]       modeSh,
  output logic [NCH:0]           clrMask
);
  localparam int A_CTRL  = 0;
  localparam int A_PRE   = 1;
  localparam int A_PER   = 2;
  localparam int A_CPRE  = 3;
  localparam int A_CPER  = 4;
  localparam int A_CCMP  = 5;
  localparam int A_CLR   = 6;
  localparam int A_CMP0  = 8;
  localparam int A_MODE0 = 16;

  logic             runReg, irReg;
  logic [PRE_W-1:0] preDiv, carPre, preCnt, carPreCnt;
  logic             mainPreTick, carTick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runReg   <= 1'b0;
      irReg    <= 1'b0;
      preDiv   <= '0;
      carPre   <= '0;
      perSh    <= '1;
      carPerSh <= '1;
      carCmpSh <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        AW'(A_CTRL): begin runReg <= wrData[0]; irReg <= wrData[1]; end
        AW'(A_PRE):  preDiv   <= wrData[PRE_W-1:0];
        AW'(A_PER):  perSh    <= wrData;
        AW'(A_CPRE): carPre   <= wrData[PRE_W-1:0];
        AW'(A_CPER): carPerSh <= wrData[CAR_W-1:0];
        AW'(A_CCMP): carCmpSh <= wrData[CAR_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chReg
    logic [CNT_W-1:0] cmpReg;
    logic [2:0]       modeReg;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpReg  <= '0;
        modeReg <= '0;
      end else if (wrEn) begin
        if (wrAddr == AW'(A_CMP0 + i))  cmpReg  <= wrData;
        if (wrAddr == AW'(A_MODE0 + i)) modeReg <= wrData[2:0];
      end
    end
    assign cmpSh[i*CNT_W +: CNT_W] = cmpReg;
    assign modeSh[i*3 +: 3]        = modeReg;
  end

  assign mainPreTick = runReg && (preCnt == preDiv);
  assign carTick     = runReg && (carPreCnt == carPre);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt    <= '0;
      carPreCnt <= '0;
    end else begin
      preCnt    <= (!runReg || mainPreTick) ? '0 : preCnt + 1'b1;
      carPreCnt <= (!runReg || carTick) ? '0 : carPreCnt + 1'b1;
    end
  end

  assign clrMask = (wrEn && wrAddr == AW'(A_CLR)) ? wrData[NCH:0] : '0;

  always_comb begin
    strb.runEn       = runReg;
    strb.irSel       = irReg;
    strb.mainPreTick = mainPreTick;
    strb.carTick     = carTick;
  end
endmodule

// File: rtl/irtp_dp.sv
module irtp_dp import irtp_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int CAR_W = 8,
  parameter int NCH   = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [CNT_W-1:0]     perSh,
  input  logic [CAR_W-1:0]     carPerSh,
  input  logic [CAR_W-1:0]     carCmpSh,
  input  logic [NCH*CNT_W-1:0] cmpSh,
  input  logic [NCH*3-1:0]     modeSh,
  input  logic [NCH:0]         clrMask,
  input  logic [NCH-1:0]       capIn,
  output logic [CNT_W-1:0]     cnt,
  output logic [CNT_W-1:0]     perAct,
  output logic [NCH-1:0]       chanOut,
  output logic                 carOut,
  output logic                 irOut,
  output logic [NCH*CNT_W-1:0] capVal,
  output logic [NCH-1:0]       chanFlag,
  output logic                 ovfFlag
);
  logic [CAR_W-1:0] carCnt, carPerAct, carCmpAct;
  logic             carWrap, mainTick, mainWrap, loadMain, loadCar;

  assign carWrap  = strb.carTick && (carCnt >= carPerAct);
  assign mainTick = strb.irSel ? carWrap : strb.mainPreTick;
  assign mainWrap = mainTick && (cnt >= perAct);
  assign loadMain = !strb.runEn || mainWrap;
  assign loadCar  = !strb.runEn || carWrap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      carCnt    <= '0;
      carPerAct <= '1;
      carCmpAct <= '0;
      cnt       <= '0;
      perAct    <= '1;
      ovfFlag   <= 1'b0;
    end else begin
      if (strb.carTick) carCnt <= carWrap ? '0 : carCnt + 1'b1;
      if (loadCar) begin
        carPerAct <= carPerSh;
        carCmpAct <= carCmpSh;
      end
      if (mainTick) cnt <= mainWrap ? '0 : cnt + 1'b1;
      if (loadMain) perAct <= perSh;
      ovfFlag <= mainWrap | (ovfFlag & ~clrMask[NCH]);
    end
  end

  assign carOut = carCnt < carCmpAct;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CNT_W-1:0] cmpAct, capReg;
    logic             flagReg, sNow, sPrev, isCap, capHit, cmpHit;

    irtp_sync u_sync (.clk(clk), .rstN(rstN), .pinIn(capIn[i]), .sNow(sNow), .sPrev(sPrev));

    assign isCap  = modeSh[i*3];
    assign capHit = isCap && ((modeSh[i*3+1] && sNow && !sPrev) ||
                              (modeSh[i*3+2] && !sNow && sPrev));
    assign cmpHit = !isCap && mainTick && (cnt == cmpAct);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpAct  <= '0;
        capReg  <= '0;
        flagReg <= 1'b0;
      end else begin
        if (loadMain) cmpAct <= cmpSh[i*CNT_W +: CNT_W];
        if (capHit)   capReg <= cnt;
        flagReg <= capHit | cmpHit | (flagReg & ~clrMask[i]);
      end
    end

    assign chanOut[i]              = !isCap && (cnt < cmpAct);
    assign capVal[i*CNT_W +: CNT_W] = capReg;
    assign chanFlag[i]             = flagReg;
  end

  assign irOut = strb.irSel & chanOut[0] & carOut;
endmodule

// File: rtl/ir_timer_pair.sv
module ir_timer_pair import irtp_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int CAR_W = 8,
  parameter int PRE_W = 8,
  parameter int NCH   = 5,
  parameter int AW    = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [AW-1:0]        wrAddr,
  input  logic [CNT_W-1:0]     wrData,
  input  logic [NCH-1:0]       capIn,
  output logic [NCH-1:0]       chanOut,
  output logic                 carOut,
  output logic                 irOut,
  output logic [CNT_W-1:0]     cnt,
  output logic [NCH*CNT_W-1:0] capVal,
  output logic [NCH-1:0]       chanFlag,
  output logic                 ovfFlag
);
  strobe_t              strb;
  logic [CNT_W-1:0]     perSh, perAct;
  logic [CAR_W-1:0]     carPerSh, carCmpSh;
  logic [NCH*CNT_W-1:0] cmpSh;
  logic [NCH*3-1:0]     modeSh;
  logic [NCH:0]         clrMask;
  logic                 runSig, irSel;

  irtp_ctrl #(.CNT_W(CNT_W), .CAR_W(CAR_W), .PRE_W(PRE_W), .NCH(NCH), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .perSh(perSh), .carPerSh(carPerSh), .carCmpSh(carCmpSh),
    .cmpSh(cmpSh), .modeSh(modeSh), .clrMask(clrMask));

  irtp_dp #(.CNT_W(CNT_W), .CAR_W(CAR_W), .NCH(NCH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .perSh(perSh), .carPerSh(carPerSh),
    .carCmpSh(carCmpSh), .cmpSh(cmpSh), .modeSh(modeSh), .clrMask(clrMask),
    .capIn(capIn), .cnt(cnt), .perAct(perAct), .chanOut(chanOut), .carOut(carOut),
    .irOut(irOut), .capVal(capVal), .chanFlag(chanFlag), .ovfFlag(ovfFlag));

  assign runSig = strb.runEn;
  assign irSel  = strb.irSel;
endmodule

// File: rtl/ir_timer_pair_chk.sv
module ir_timer_pair_chk #(
  parameter int CNT_W = 16,
  parameter int NCH   = 5,
  parameter int AW    = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [AW-1:0]    wrAddr,
  input logic [CNT_W-1:0] wrData,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] perAct,
  input logic             runSig,
  input logic             irSel,
  input logic             irOut,
  input logic             carOut,
  input logic [NCH-1:0]   chanOut,
  input logic [NCH-1:0]   chanFlag,
  input logic             ovfFlag
);
  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != $past(cnt)) |-> ((cnt - $past(cnt)) == CNT_W'(1) || cnt == '0));

  // R2
  ovf_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> (cnt == '0));

  // R3
  period_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runSig && $past(runSig) && perAct != $past(perAct)) |-> (cnt == '0));

  // R6
  ir_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irSel |-> !irOut);

  // R6
  ir_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irOut |-> (carOut && chanOut[0]));

  for (genvar i = 0; i < NCH; i++) begin : g_flag
    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(chanFlag[i]) |-> $past(wrEn && wrAddr == AW'(6) && wrData[i]));
  end
endmodule

bind ir_timer_pair ir_timer_pair_chk #(.CNT_W(CNT_W), .NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .cnt(cnt), .perAct(perAct), .runSig(runSig), .irSel(irSel), .irOut(irOut),
  .carOut(carOut), .chanOut(chanOut), .chanFlag(chanFlag), .ovfFlag(ovfFlag));

// File: tb/sim_ir_timer_pair.sv
`timescale 1ns/1ps
module sim_ir_timer_pair;
  localparam int NCH = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [4:0]  capIn = '0;
  logic [4:0]  chanOut;
  logic        carOut, irOut, ovfFlag;
  logic [15:0] cnt;
  logic [79:0] capVal;
  logic [4:0]  chanFlag;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ir_timer_pair u0 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .capIn(capIn), .chanOut(chanOut), .carOut(carOut), .irOut(irOut), .cnt(cnt),
    .capVal(capVal), .chanFlag(chanFlag), .ovfFlag(ovfFlag));

  task automatic chk(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference model
  int mRun, mIr, mPre, mPer, mCPre, mCPer, mCCmp;
  int mCmp[NCH], mMode[NCH];
  int pc, cpc, c, cc, pa, cpa, cca, ov;
  int ca[NCH], s1[NCH], s2[NCH], s3[NCH], cv[NCH], fl[NCH];

  always @(posedge clk) begin
    int mpt, ct, cw, tk, wp, clr, hit;
    if (!rstN) begin
      mRun = 0; mIr = 0; mPre = 0; mPer = 65535; mCPre = 0; mCPer = 255; mCCmp = 0;
      pc = 0; cpc = 0; c = 0; cc = 0; pa = 65535; cpa = 255; cca = 0; ov = 0;
      for (int k = 0; k < NCH; k++) begin
        mCmp[k] = 0; mMode[k] = 0; ca[k] = 0; s1[k] = 0; s2[k] = 0; s3[k] = 0;
        cv[k] = 0; fl[k] = 0;
      end
    end else begin
      mpt = (mRun != 0 && pc == mPre) ? 1 : 0;
      ct  = (mRun != 0 && cpc == mCPre) ? 1 : 0;
      cw  = (ct != 0 && cc >= cpa) ? 1 : 0;
      tk  = (mIr != 0) ? cw : mpt;
      wp  = (tk != 0 && c >= pa) ? 1 : 0;
      clr = (wrEn && wrAddr == 5'd6) ? int'(wrData) : 0;
      for (int k = 0; k < NCH; k++) begin
        hit = 0;
        if ((mMode[k] & 1) != 0) begin
          if (((mMode[k] & 2) != 0 && s2[k] == 1 && s3[k] == 0) ||
              ((mMode[k] & 4) != 0 && s2[k] == 0 && s3[k] == 1)) begin
            hit = 1; cv[k] = c;
          end
        end else if (tk != 0 && c == ca[k]) hit = 1;
        fl[k] = (hit != 0 || (fl[k] != 0 && ((clr >> k) & 1) == 0)) ? 1 : 0;
      end
      ov = (wp != 0 || (ov != 0 && ((clr >> 5) & 1) == 0)) ? 1 : 0;
      if (ct != 0) cc = (cw != 0) ? 0 : cc + 1;
      if (tk != 0) c = (wp != 0) ? 0 : c + 1;
      if (mRun == 0 || cw != 0) begin cpa = mCPer; cca = mCCmp; end
      if (mRun == 0 || wp != 0) begin
        pa = mPer;
        for (int k = 0; k < NCH; k++) ca[k] = mCmp[k];
      end
      pc  = (mRun == 0 || mpt != 0) ? 0 : pc + 1;
      cpc = (mRun == 0 || ct != 0) ? 0 : cpc + 1;
      for (int k = 0; k < NCH; k++) begin
        s3[k] = s2[k]; s2[k] = s1[k]; s1[k] = int'(capIn[k]);
      end
      if (wrEn) begin
        case (wrAddr)
          5'd0: begin mRun = int'(wrData[0]); mIr = int'(wrData[1]); end
          5'd1: mPre = int'(wrData[7:0]);
          5'd2: mPer = int'(wrData);
          5'd3: mCPre = int'(wrData[7:0]);
          5'd4: mCPer = int'(wrData[7:0]);
          5'd5: mCCmp = int'(wrData[7:0]);
          default: begin
            if (wrAddr >= 5'd8 && wrAddr < 5'd8 + NCH) mCmp[wrAddr - 5'd8] = int'(wrData);
            if (wrAddr >= 5'd16 && wrAddr < 5'd16 + NCH) mMode[wrAddr - 5'd16] = int'(wrData[2:0]);
          end
        endcase
      end
    end
  end

  // Cycle compare against the model
  always @(negedge clk) begin
    int eo, ec;
    if (rstN && !done) begin
      chk("R1 count", cnt, c);
      chk("R2 overflow flag", ovfFlag, ov);
      ec = (cc < cca) ? 1 : 0;
      chk("R5 carrier out", carOut, ec);
      eo = 0;
      for (int k = 0; k < NCH; k++) begin
        int e;
        e = ((mMode[k] & 1) == 0 && c < ca[k]) ? 1 : 0;
        if (k == 0) eo = e;
        chk("R4 channel out", chanOut[k], e);
        chk("R9 channel flag", chanFlag[k], fl[k]);
        chk("R7 capture value", capVal[k*16 +: 16], cv[k]);
      end
      chk("R6 ir out", irOut, (mIr != 0 && eo != 0 && ec != 0) ? 1 : 0);
    end
  end

  task automatic wr(input int a, input int d);
    wrEn = 1'b1; wrAddr = 5'(a); wrData = 16'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int mx, irHigh;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 reset count", cnt, 0);
    chk("R10 reset outputs", chanOut, 0);
    chk("R10 reset flags", chanFlag, 0);
    chk("R10 reset overflow", ovfFlag, 0);
    chk("R10 reset capture", capVal[15:0], 0);

    wr(1, 1); wr(2, 9); wr(8, 4); wr(9, 7);
    wr(18, 3); wr(19, 5); wr(20, 7);
    wr(3, 1); wr(4, 5); wr(5, 3);
    wr(0, 1);
    repeat (7) @(negedge clk);

    capIn[2] = 1'b1; @(negedge clk); capIn[2] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 one-clock pulse seen", chanFlag[2], 1);

    capIn[3] = 1'b1; capIn[4] = 1'b1;
    repeat (3) @(negedge clk);
    capIn[3] = 1'b0;
    repeat (2) @(negedge clk);
    capIn[4] = 1'b0;
    repeat (5) @(negedge clk);
    chk("R7 falling capture flag", chanFlag[3], 1);

    while (cnt != 16'd2) @(negedge clk);
    wr(2, 5);
    mx = 0;
    while (cnt != 16'd0) begin if (int'(cnt) > mx) mx = int'(cnt); @(negedge clk); end
    chk("R3 old period finishes", mx, 9);
    while (cnt == 16'd0) @(negedge clk);
    mx = 0;
    while (cnt != 16'd0) begin if (int'(cnt) > mx) mx = int'(cnt); @(negedge clk); end
    chk("R3 new period after wrap", mx, 5);

    repeat (40) wr(6, 16'h3F);
    repeat (3) @(negedge clk);

    wr(0, 0);
    mx = int'(cnt);
    repeat (10) @(negedge clk);
    chk("R1 stopped counter holds", cnt, mx);

    wr(3, 0); wr(4, 3); wr(5, 2); wr(2, 4); wr(8, 2);
    wr(0, 3);
    irHigh = 0;
    repeat (80) begin @(negedge clk); if (irOut) irHigh++; end
    chk("R6 ir bursts present", (irHigh > 0) ? 1 : 0, 1);

    wr(0, 1);
    irHigh = 0;
    repeat (20) begin @(negedge clk); if (irOut) irHigh++; end
    chk("R6 ir silent when off", irHigh, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule